// File: doc/BRIEF.md
# Time-Base Interval and Watchdog Event Unit

This block watches a free-running 64-bit time base and produces two kinds of periodic event from it. One is a fixed-interval tick and the other is a watchdog tick. For each event, software picks a time base bit through a control register. The event fires each time that bit goes from 0 to 1. A fixed-interval event sets a sticky status flag. Each status flag can drive an interrupt output when its enable bit is set, and software clears the flags by writing ones to the status register.

The watchdog escalates over successive events:
- The first unserviced event arms the next-watchdog flag.
- The second sets the watchdog interrupt flag.
- The third copies the reset-control field into the reset-status field and raises a one-cycle reset request, provided reset control is nonzero.

Software services the watchdog by clearing the flags before the next event arrives. Producing the time base, taking the interrupts and performing the reset all happen outside this block.

Top module: `tbase_event_unit`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, both interrupt outputs are 0 and the reset request is 0.
- R2: A control write (`ctl_we`=1) stores all 32 bits of `ctl_wdata`. The new value appears on `ctl_q` after the clock edge.
- R3: The control fields are laid out as follows.
  - Watchdog select is bits 31:30 and watchdog extension is bits 20:17.
  - Watchdog reset control is bits 29:28 and watchdog interrupt enable is bit 27.
  - Fixed-interval select is bits 25:24 and fixed-interval extension is bits 16:13.
  - Fixed-interval interrupt enable is bit 23.
  - With `EXTENDED`=1, the time base bit watched is 63 − (select | extension<<2). Index 63 is the most significant bit.
- R4: The time base is sampled once per clock. An event occurs in a cycle where the watched bit is 1 and was 0 at the previous sample, and the status change is visible after that edge. A bit that stays at 1, or that falls, gives no event. The first sample after reset never gives an event.
- R5: A fixed-interval event sets status bit 26. `fit_irq` equals status bit 26 AND control bit 23.
- R6: A watchdog event while status bit 31 (next-watchdog enable) is 0 sets bit 31 and nothing else.
- R7: A watchdog event while bit 31 is 1 and bit 30 is 0 sets bit 30. `wdt_irq` equals status bit 30 AND control bit 27.
- R8: A watchdog event while bits 31 and 30 are both 1 acts on the reset control field.
  - If the field is nonzero, its value is copied into status bits 29:28 and `rst_req` is high for exactly one cycle.
  - If the field is zero, the status register and `rst_req` do not change.
- R9: A status write (`sts_we`=1) clears each bit written as 1 and leaves bits written as 0 unchanged. Status bits other than 31, 30, 29:28 and 26 always read 0.
- R10: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R11: Changing the selected bit through a control write does not by itself produce an event while the time base is held constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbase | input | 64 | Time base value |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| sts_we | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 32 | Status clear mask |
| ctl_q | output | 32 | Control register contents |
| sts_q | output | 32 | Status register contents |
| fit_irq | output | 1 | Fixed-interval interrupt |
| wdt_irq | output | 1 | Watchdog interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest state to reach is the final watchdog stage. It needs three separate rising edges of the selected bit with no service in between, and it must be reached once with a nonzero reset control and once with zero. The bench drives the time base directly rather than letting it count, so it places each rising edge of a low bit on a chosen cycle. It also steps through the flags one stage at a time and clears only the reset-status field between the two final-stage runs. The set-versus-clear collision is reached the same way: the rising edge and the status write are placed in one cycle.

// File: rtl/tbase_event_unit.sv
module tbase_event_unit #(
  parameter bit EXTENDED = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] tbase,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  input  logic        sts_we,
  input  logic [31:0] sts_wdata,
  output logic [31:0] ctl_q,
  output logic [31:0] sts_q,
  output logic        fit_irq,
  output logic        wdt_irq,
  output logic        rst_req
);
  localparam logic [31:0] STS_MASK = 32'hF400_0000;
  localparam logic [5:0]  TOP_BIT  = 6'd63;

  logic [31:0] ctl, sts, sts_d, set_m;
  logic [63:0] tb_prev;
  logic        primed;

  wire [3:0] fit_ext  = EXTENDED ? ctl[16:13] : 4'd0;
  wire [3:0] wdt_ext  = EXTENDED ? ctl[20:17] : 4'd0;
  wire [5:0] fit_idx  = TOP_BIT - {fit_ext, ctl[25:24]};
  wire [5:0] wdt_idx  = TOP_BIT - {wdt_ext, ctl[31:30]};

  wire fit_evt = primed && !tb_prev[fit_idx] && tbase[fit_idx];
  wire wdt_evt = primed && !tb_prev[wdt_idx] && tbase[wdt_idx];

  wire wdt_last = wdt_evt && sts[31] && sts[30] && (ctl[29:28] != 2'd0);
  wire [31:0] clr = sts_we ? sts_wdata : 32'd0;

  always_comb begin
    set_m     = 32'd0;
    set_m[26] = fit_evt;
    set_m[31] = wdt_evt && !sts[31];
    set_m[30] = wdt_evt && sts[31] && !sts[30];
    sts_d     = ((sts & ~clr) | set_m) & STS_MASK;
    if (wdt_last) sts_d[29:28] = ctl[29:28];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl     <= '0;
      sts     <= '0;
      tb_prev <= '0;
      primed  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (ctl_we) ctl <= ctl_wdata;
      sts     <= sts_d;
      tb_prev <= tbase;
      primed  <= 1'b1;
      rst_req <= wdt_last;
    end
  end

  assign ctl_q   = ctl;
  assign sts_q   = sts;
  assign fit_irq = sts[26] && ctl[23];
  assign wdt_irq = sts[30] && ctl[27];
endmodule

module tbase_event_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sts_we,
  input logic [31:0] sts_wdata,
  input logic [31:0] sts_q,
  input logic        rst_req
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R8
  AST_RST_AFTER_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(sts_q[31]) && $past(sts_q[30]))); // R8
  AST_RST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (sts_q[29:28] != 2'd0)); // R8
  AST_WIS_AFTER_ENW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[30]) |-> $past(sts_q[31])); // R7
  AST_FIS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[26] && !(sts_we && sts_wdata[26])) |=> sts_q[26]); // R9
endmodule

bind tbase_event_unit tbase_event_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sts_we(sts_we), .sts_wdata(sts_wdata),
  .sts_q(sts_q), .rst_req(rst_req)
);

// File: tb/sim_tbase_event_unit.sv
module sim_tbase_event_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [63:0] tbase = '0;
  logic ctl_we = 1'b0, sts_we = 1'b0;
  logic [31:0] ctl_wdata = '0, sts_wdata = '0;
  logic [31:0] ctl_q, sts_q;
  logic fit_irq, wdt_irq, rst_req;
  int checks = 0, failures = 0;

  tbase_event_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkctl(input logic [1:0] wp, input logic [3:0] wext,
      input logic [1:0] wrc, input logic wie, input logic [1:0] fp, input logic [3:0] fext, input logic fie);
    logic [31:0] v = '0;
    v[31:30] = wp; v[29:28] = wrc; v[27] = wie; v[25:24] = fp;
    v[23] = fie; v[20:17] = wext; v[16:13] = fext;
    return v;
  endfunction

  task automatic step(input logic [63:0] v);
    @(negedge clk); tbase = v;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_sts(input logic [31:0] v);
    @(negedge clk); sts_we = 1'b1; sts_wdata = v;
    @(negedge clk); sts_we = 1'b0;
  endtask

  task automatic t_reset;
    chk(ctl_q == 0, "R1 ctl", ctl_q, 0);
    chk(sts_q == 0, "R1 sts", sts_q, 0);
    chk({fit_irq, wdt_irq, rst_req} == 0, "R1 outs", {fit_irq, wdt_irq, rst_req}, 0);
  endtask

  task automatic t_ctl;
    wr_ctl(32'hA5C3_7E19);
    chk(ctl_q == 32'hA5C3_7E19, "R2 readback", ctl_q, 32'hA5C3_7E19);
    wr_ctl(32'h0);
  endtask

  task automatic t_fit;
    wr_ctl(mkctl(0, 0, 0, 0, 2, 15, 1)); // fit on bit 1
    step(1);
    chk(sts_q[26] == 0, "R4 no event bit0", sts_q, 0);
    step(2);
    chk(sts_q == 32'h0400_0000, "R5 fit status", sts_q, 32'h0400_0000);
    chk(fit_irq == 1, "R5 fit_irq on", fit_irq, 1);
    wr_ctl(mkctl(0, 0, 0, 0, 2, 15, 0));
    chk(fit_irq == 0, "R5 fit_irq gated", fit_irq, 0);
  endtask

  task automatic t_w1c;
    wr_sts(32'h0BFF_FFFF);
    chk(sts_q == 32'h0400_0000, "R9 zero bits keep", sts_q, 32'h0400_0000);
    wr_sts(32'h0400_0000);
    chk(sts_q == 0, "R9 cleared", sts_q, 0);
  endtask

  task automatic t_hold;
    step(3);
    chk(sts_q[26] == 0, "R4 stays high", sts_q, 0);
    step(4);
    chk(sts_q[26] == 0, "R4 falls", sts_q, 0);
    step(6);
    chk(sts_q[26] == 1, "R4 rise again", sts_q, 32'h0400_0000);
    wr_sts(32'hFFFF_FFFF);
  endtask

  task automatic t_sel;
    step(2);
    wr_ctl(mkctl(0, 0, 0, 0, 1, 15, 0)); // bit 2, held 0 then 1? tbase=2 -> bit2=0
    wr_ctl(mkctl(0, 0, 0, 0, 2, 15, 0)); // back to bit 1, which is 1
    step(2);
    chk(sts_q[26] == 0, "R11 select change", sts_q, 0);
    wr_ctl(mkctl(0, 0, 0, 0, 1, 15, 0));
    step(4);
    chk(sts_q[26] == 1, "R3 bit2 event", sts_q, 32'h0400_0000);
    wr_sts(32'hFFFF_FFFF);
  endtask

  task automatic t_wdt;
    wr_ctl(mkctl(3, 14, 2, 1, 0, 0, 0)); // wdt on bit 4
    step(0);
    step(8);
    chk(sts_q == 0, "R3 bit3 ignored", sts_q, 0);
    step(16);
    chk(sts_q == 32'h8000_0000, "R6 stage one", sts_q, 32'h8000_0000);
    chk(wdt_irq == 0, "R6 no irq", wdt_irq, 0);
    step(0); step(16);
    chk(sts_q == 32'hC000_0000, "R7 stage two", sts_q, 32'hC000_0000);
    chk(wdt_irq == 1, "R7 wdt_irq", wdt_irq, 1);
    step(0); step(16);
    chk(sts_q == 32'hE000_0000, "R8 reset status", sts_q, 32'hE000_0000);
    chk(rst_req == 1, "R8 req high", rst_req, 1);
    step(16);
    chk(rst_req == 0, "R8 req one cycle", rst_req, 0);
    wr_sts(32'h3000_0000);
    wr_ctl(mkctl(3, 14, 0, 1, 0, 0, 0));
    step(0); step(16);
    chk(sts_q == 32'hC000_0000, "R8 zero ctl no change", sts_q, 32'hC000_0000);
    chk(rst_req == 0, "R8 zero ctl no req", rst_req, 0);
    wr_sts(32'hFFFF_FFFF);
  endtask

  task automatic t_collide;
    wr_ctl(mkctl(0, 0, 0, 0, 3, 15, 0)); // fit on bit 0
    step(0);
    @(negedge clk); tbase = 1; sts_we = 1'b1; sts_wdata = 32'h0400_0000;
    @(posedge clk); @(negedge clk); sts_we = 1'b0;
    chk(sts_q[26] == 1, "R10 set wins", sts_q, 32'h0400_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_ctl; t_fit; t_w1c; t_hold; t_sel; t_wdt; t_collide;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule